// File: doc/BRIEF.md
# FIFO-Drained Parallel Output Port

This block empties a local first-word-fall-through sample FIFO onto a 16-line parallel port that a remote receiver reads. The port is a slave with no address lines: words go out strictly in the order the FIFO holds them. Each word is offered with an active-low ready strobe and is retired by a four-phase exchange on an active-low acknowledge line. The remote side also drives a transfer-enable line. While it is low, no new word is offered. Its synchronised level is brought out as a status bit for the host.

A host-controlled steering bit decides who consumes the FIFO. When the bit is set, the parallel port drains it and host read strobes are ignored. When the bit is clear, the port stays idle and each host read strobe pops one word for the host bus. Both remote inputs are asynchronous and pass through two-flop synchronisers before any logic uses them. Reset is synchronous and active high.

Top module: `pport_drain`

## Requirements
- R1: During and directly after reset, port_rdy_n is 1, fifo_pop is 0, port_data is 0 and stat_rem_en is 0.
- R2: port_rdy_n goes to 0 only on the clock edge after a cycle in which steer_en is 1, the synchronised transfer-enable is 1, fifo_empty is 0 and the synchronised acknowledge is released. When that cycle follows a rise of rem_xfer_en, port_rdy_n falls on the third rising edge after the rise.
- R3: port_data holds its value for as long as port_rdy_n stays 0.
- R4: Every word is offered exactly as the FIFO head held it, in FIFO order, with none lost or repeated. A word that was withdrawn is offered again later.
- R5: After rem_ack_n falls, port_rdy_n returns to 1 on the third rising edge. On that same edge fifo_pop rises for exactly one cycle.
- R6: After an acknowledge, no new word is offered while rem_ack_n stays low. Once rem_ack_n rises, the next word appears (port_rdy_n = 0) on the fourth rising edge.
- R7: stat_rem_en follows rem_xfer_en two rising edges after each change.
- R8: While steer_en is 0 or the transfer-enable is low, port_rdy_n stays 1 and the port pops nothing. If steer_en drops while a word is offered and no acknowledge has arrived, port_rdy_n returns to 1 on the next edge and that word stays in the FIFO.
- R9: With steer_en at 0, host_rd pops one word per cycle (fifo_pop = 1 in the same cycle) when the FIFO is not empty. With steer_en at 1, host_rd has no effect on fifo_pop.
- R10: fifo_pop is never 1 while fifo_empty is 1. With an empty FIFO, port_rdy_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| steer_en | input | 1 | 1: FIFO drains to the parallel port; 0: FIFO drains to the host |
| host_rd | input | 1 | Host read strobe, one pop per cycle when steering is clear |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rd_data | input | 16 | FIFO head word (first-word-fall-through) |
| fifo_pop | output | 1 | Remove the head word at this clock edge |
| rem_xfer_en | input | 1 | Remote transfer enable, asynchronous, active high |
| rem_ack_n | input | 1 | Remote acknowledge, asynchronous, active low |
| port_rdy_n | output | 1 | Word valid on port_data, active low |
| port_data | output | 16 | Parallel data lines |
| stat_rem_en | output | 1 | Synchronised transfer-enable status for the host |

## Verification
Each result has a fixed delay from the stimulus that causes it. stat_rem_en changes two edges after rem_xfer_en, and the first offer follows one edge later. The ready release and the pop pulse land on the third edge after an acknowledge. The next offer lands on the fourth edge after the acknowledge is released, and a withdrawal lands on the first edge after steering drops. The host pop is combinational in the same cycle. All stimulus is applied on the falling clock edge, and each timed check counts rising edges from that point. It samples one edge early, to see that nothing has changed yet, and again on the exact due edge. The streamed words are compared in order against a queue that the push task fills.

// File: rtl/ppd_pkg.sv
package ppd_pkg;

    localparam int PPD_DATA_W = 16;
    localparam int PPD_SYNC_N = 2;

    typedef enum logic [1:0] {
        PD_IDLE  = 2'd0,
        PD_SHOW  = 2'd1,
        PD_DRAIN = 2'd2
    } pd_state_e;

    typedef struct packed {
        pd_state_e st;
        logic      rdy_n;
        logic      pop;
    } pd_ctl_t;

    localparam pd_ctl_t PD_CTL_RESET = '{st: PD_IDLE, rdy_n: 1'b1, pop: 1'b0};

    // A word may be offered when routing, remote permission and data all agree
    function automatic logic pd_may_offer(input logic steer, input logic xen,
                                          input logic empty, input logic ack);
        return steer & xen & ~empty & ~ack;
    endfunction

endpackage

// File: rtl/ppd_sync.sv
module ppd_sync #(
    parameter int              W       = 2,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d_async;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/ppd_word_hold.sv
module ppd_word_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst)       dout <= '0;
        else if (load) dout <= din;
    end
endmodule

// File: rtl/ppd_hs_fsm.sv
module ppd_hs_fsm
    import ppd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic steer_en,
    input  logic xen_s,
    input  logic ack_s,
    input  logic fifo_empty,
    output logic load,
    output logic rdy_n,
    output logic pop
);
    pd_ctl_t cur, nxt;

    always_comb begin
        nxt     = cur;
        nxt.pop = 1'b0;
        load    = 1'b0;
        unique case (cur.st)
            PD_IDLE: begin
                if (pd_may_offer(steer_en, xen_s, fifo_empty, ack_s)) begin
                    load      = 1'b1;
                    nxt.st    = PD_SHOW;
                    nxt.rdy_n = 1'b0;
                end
            end
            PD_SHOW: begin
                if (ack_s) begin
                    nxt.st    = PD_DRAIN;
                    nxt.rdy_n = 1'b1;
                    nxt.pop   = 1'b1;
                end else if (!steer_en || !xen_s) begin
                    nxt.st    = PD_IDLE;
                    nxt.rdy_n = 1'b1;
                end
            end
            PD_DRAIN: begin
                if (!ack_s) nxt.st = PD_IDLE;
            end
            default: nxt = PD_CTL_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= PD_CTL_RESET;
        else     cur <= nxt;
    end

    assign rdy_n = cur.rdy_n;
    assign pop   = cur.pop;
endmodule

// File: rtl/pport_drain.sv
module pport_drain
    import ppd_pkg::*;
#(
    parameter int DATA_W = PPD_DATA_W,
    parameter int SYNC_N = PPD_SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              steer_en,
    input  logic              host_rd,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_rd_data,
    output logic              fifo_pop,
    input  logic              rem_xfer_en,
    input  logic              rem_ack_n,
    output logic              port_rdy_n,
    output logic [DATA_W-1:0] port_data,
    output logic              stat_rem_en
);
    localparam int NSYNC = 2;
    localparam logic [NSYNC-1:0] SYNC_RST = 2'b10; // {ack_n idle high, enable low}

    logic [NSYNC-1:0] raw_in, synced;
    logic ack_s, xen_s, load, port_pop, host_pop;

    assign raw_in = {rem_ack_n, rem_xfer_en};

    ppd_sync #(.W(NSYNC), .STAGES(SYNC_N), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst(rst), .d_async(raw_in), .q_sync(synced)
    );

    assign ack_s = ~synced[1];
    assign xen_s = synced[0];

    ppd_hs_fsm u_fsm (
        .clk(clk), .rst(rst), .steer_en(steer_en), .xen_s(xen_s),
        .ack_s(ack_s), .fifo_empty(fifo_empty), .load(load),
        .rdy_n(port_rdy_n), .pop(port_pop)
    );

    ppd_word_hold #(.W(DATA_W)) u_hold (
        .clk(clk), .rst(rst), .load(load), .din(fifo_rd_data), .dout(port_data)
    );

    assign host_pop    = host_rd & ~steer_en & ~fifo_empty;
    assign fifo_pop    = port_pop | host_pop;
    assign stat_rem_en = xen_s;
endmodule

// File: rtl/pport_drain_chk.sv
module pport_drain_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              steer_en,
    input logic              host_rd,
    input logic              fifo_empty,
    input logic              fifo_pop,
    input logic              port_rdy_n,
    input logic [DATA_W-1:0] port_data,
    input logic              stat_rem_en,
    input logic              ack_s,
    input logic              port_pop
);
    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (port_rdy_n && !port_pop && port_data == '0 && !stat_rem_en));

    // R2
    a_r2_offer_needs_all: assert property (@(posedge clk) disable iff (rst)
        $fell(port_rdy_n) |-> ($past(steer_en) && $past(stat_rem_en) && !$past(fifo_empty)));

    // R3
    a_r3_hold_word: assert property (@(posedge clk) disable iff (rst)
        (!port_rdy_n && $past(!port_rdy_n)) |-> $stable(port_data));

    // R5
    a_r5_pop_single: assert property (@(posedge clk) disable iff (rst)
        port_pop |=> !port_pop);

    // R5
    a_r5_pop_with_release: assert property (@(posedge clk) disable iff (rst)
        port_pop |-> $rose(port_rdy_n));

    // R6
    a_r6_wait_release: assert property (@(posedge clk) disable iff (rst)
        $fell(port_rdy_n) |-> !$past(ack_s));

    // R9
    a_r9_host_blocked: assert property (@(posedge clk) disable iff (rst)
        (steer_en && host_rd && !port_pop) |-> !fifo_pop);

    // R10
    a_r10_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> !fifo_empty);
endmodule

bind pport_drain pport_drain_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .steer_en(steer_en), .host_rd(host_rd),
    .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .port_rdy_n(port_rdy_n),
    .port_data(port_data), .stat_rem_en(stat_rem_en), .ack_s(ack_s),
    .port_pop(port_pop)
);

// File: tb/pport_drain_test.sv
module pport_drain_test;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic steer_en = 1'b0, host_rd = 1'b0;
    logic fifo_empty = 1'b1;
    logic [DW-1:0] fifo_rd_data = '0;
    logic fifo_pop;
    logic rem_xfer_en = 1'b0, rem_ack_n = 1'b1;
    logic port_rdy_n;
    logic [DW-1:0] port_data;
    logic stat_rem_en;

    int total = 0, bad = 0, rx_cnt = 0;
    bit auto_rx = 1'b0;
    bit done = 1'b0;
    logic [DW-1:0] mem[$];
    logic [DW-1:0] exp_q[$];

    always #4 clk = ~clk;

    pport_drain uut (
        .clk(clk), .rst(rst), .steer_en(steer_en), .host_rd(host_rd),
        .fifo_empty(fifo_empty), .fifo_rd_data(fifo_rd_data), .fifo_pop(fifo_pop),
        .rem_xfer_en(rem_xfer_en), .rem_ack_n(rem_ack_n), .port_rdy_n(port_rdy_n),
        .port_data(port_data), .stat_rem_en(stat_rem_en)
    );

    task automatic refresh();
        fifo_empty   = (mem.size() == 0);
        fifo_rd_data = (mem.size() == 0) ? '0 : mem[0];
    endtask

    // FIFO model: pops on the edge where fifo_pop is high
    always @(posedge clk) begin
        if (fifo_pop && mem.size() > 0) begin
            void'(mem.pop_front());
            refresh();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] w);
        mem.push_back(w);
        exp_q.push_back(w);
        refresh();
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor / remote receiver: pops expected words and compares
    initial begin
        forever begin
            @(negedge clk);
            if (auto_rx && !port_rdy_n && rem_ack_n) begin
                if (exp_q.size() == 0) check(1'b0, "R4 extra word", port_data, 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(port_data == e, "R4 stream order", port_data, e);
                end
                rx_cnt++;
                rem_ack_n = 1'b0;
                while (!port_rdy_n) @(negedge clk);
                rem_ack_n = 1'b1;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        refresh();
        edges(3);
        // R1 reset state
        check(port_rdy_n == 1'b1, "R1 rdy_n", port_rdy_n, 1);
        check(fifo_pop == 1'b0, "R1 pop", fifo_pop, 0);
        check(port_data == '0, "R1 data", port_data, 0);
        check(stat_rem_en == 1'b0, "R1 status", stat_rem_en, 0);
        rst = 1'b0;

        // R8: steering clear, remote enabled, data present -> no offer
        rem_xfer_en = 1'b1;
        push(16'hA001); push(16'hB002); push(16'hC003);
        edges(10);
        check(port_rdy_n == 1'b1, "R8 steer off rdy", port_rdy_n, 1);
        check(mem.size() == 3, "R8 steer off no pop", mem.size(), 3);

        // R9: host read pops while steering clear
        host_rd = 1'b1; #1;
        check(fifo_pop == 1'b1, "R9 host pop", fifo_pop, 1);
        @(negedge clk); host_rd = 1'b0;
        void'(exp_q.pop_front());
        check(mem.size() == 2, "R9 host pop count", mem.size(), 2);

        // R8: remote disabled, steering set
        rem_xfer_en = 1'b0; steer_en = 1'b1;
        edges(8);
        check(stat_rem_en == 1'b0, "R7 status low", stat_rem_en, 0);
        check(port_rdy_n == 1'b1, "R8 remote off rdy", port_rdy_n, 1);
        // R9: host read ignored while steering set
        host_rd = 1'b1; #1;
        check(fifo_pop == 1'b0, "R9 host blocked", fifo_pop, 0);
        @(negedge clk); host_rd = 1'b0;
        check(mem.size() == 2, "R9 host blocked count", mem.size(), 2);

        // R7 / R2 timing from enable rise
        rem_xfer_en = 1'b1;
        edges(1);
        check(stat_rem_en == 1'b0, "R7 status after 1 edge", stat_rem_en, 0);
        edges(1);
        check(stat_rem_en == 1'b1, "R7 status after 2 edges", stat_rem_en, 1);
        check(port_rdy_n == 1'b1, "R2 not yet offered", port_rdy_n, 1);
        edges(1);
        check(port_rdy_n == 1'b0, "R2 offer on 3rd edge", port_rdy_n, 0);
        check(port_data == exp_q[0], "R4 first word", port_data, exp_q[0]);
        edges(5);
        check(port_data == exp_q[0], "R3 word held", port_data, exp_q[0]);

        // R5 acknowledge timing
        rem_ack_n = 1'b0;
        edges(2);
        check(port_rdy_n == 1'b0, "R5 rdy still low", port_rdy_n, 0);
        edges(1);
        check(port_rdy_n == 1'b1, "R5 rdy released", port_rdy_n, 1);
        check(fifo_pop == 1'b1, "R5 pop pulse", fifo_pop, 1);
        edges(1);
        check(fifo_pop == 1'b0, "R5 pop single", fifo_pop, 0);
        check(mem.size() == 1, "R5 one word popped", mem.size(), 1);
        void'(exp_q.pop_front());

        // R6: hold acknowledge, nothing new offered
        edges(10);
        check(port_rdy_n == 1'b1, "R6 held ack no offer", port_rdy_n, 1);
        rem_ack_n = 1'b1;
        edges(3);
        check(port_rdy_n == 1'b1, "R6 not before 4th edge", port_rdy_n, 1);
        edges(1);
        check(port_rdy_n == 1'b0, "R6 next word on 4th edge", port_rdy_n, 0);
        check(port_data == exp_q[0], "R4 second word", port_data, exp_q[0]);

        // R8 withdrawal on steering drop
        steer_en = 1'b0;
        edges(1);
        check(port_rdy_n == 1'b1, "R8 withdraw rdy", port_rdy_n, 1);
        edges(3);
        check(mem.size() == 1, "R8 withdraw no pop", mem.size(), 1);
        steer_en = 1'b1;
        edges(1);
        check(port_rdy_n == 1'b0, "R4 re-offer", port_rdy_n, 0);
        check(port_data == exp_q[0], "R4 re-offer word", port_data, exp_q[0]);

        // R4 streaming scoreboard
        auto_rx = 1'b1;
        fork
            begin
                for (int i = 0; i < 20; i++) begin
                    push(16'h1000 + 16'(i * 37));
                    repeat (i % 4) @(negedge clk);
                    @(negedge clk);
                end
            end
        join
        for (int k = 0; k < 2000 && (exp_q.size() != 0 || mem.size() != 0); k++) @(negedge clk);
        edges(12);
        check(rx_cnt == 21, "R4 word count", rx_cnt, 21);
        check(exp_q.size() == 0, "R4 nothing left", exp_q.size(), 0);

        // R10: empty FIFO -> idle
        check(port_rdy_n == 1'b1, "R10 empty rdy", port_rdy_n, 1);
        check(fifo_pop == 1'b0, "R10 empty pop", fifo_pop, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule